// File: doc/BRIEF.md
# Keyed Watchdog Reset Controller

This block is a watchdog timer on a simple synchronous register bus. Software loads a 20-bit tick count and arms the timer through a configuration field in a separate control register. A dedicated `tick_en` strobe then counts the value down. The system integrator derives that strobe from the system clock so that it pulses 65536 times per second, which gives a longest timeout of about 16 seconds. If software does not reload the count in time, the count reaches zero. The block then drives a one-cycle reset request, disarms itself and records the cause in a status register.

Every bus write is gated by a key byte. A write reaches a register only when write data bits 31:24 hold 0x5A. Stray or corrupted writes therefore cannot arm, stop or feed the timer.

The status register holds software-defined bits that survive the reset request. It changes only through keyed writes and the watchdog-expiry flag. The same reset-request mechanism serves for a deliberate quick restart: load a small count such as 10 ticks and arm the timer, and the reset follows about 150 µs later.

Top module: `wdog_reset_ctrl`

## Requirements
- R1: A write whose data bits 31:24 differ from 0x5A leaves the control, status and count registers unchanged.
- R2: The control register is at byte offset 0x1C, status at 0x20 and count at 0x24. Read data appears on `bus_rdata` one clock after the address is presented. Any other offset reads as zero.
- R3: The count register is 20 bits in data bits 19:0. Data bits 23:20 of a keyed write are discarded, and a read returns the ticks remaining.
- R4: When control bit 5 is 1 (the configuration field in bits 5:4 equals 2), the count drops by one on each clock with `tick_en` high. When bit 5 is 0, the count holds.
- R5: A keyed write of 0x102 to the control register clears bit 5 and stops the countdown. The control register reads back the written low 12 bits.
- R6: When armed, a count of N≥1 makes `reset_req` rise on the clock edge that samples the Nth tick, and a count of 0 makes it rise on the next tick. `reset_req` lasts exactly one clock.
- R7: On expiry, control bits 5:4 clear to 0, status bit 5 sets and the count reads 0. Expiry wins over a control write in the same cycle.
- R8: A keyed write sets status bits 11:0. Those bits, including the even bits 0, 2, 4, 6, 8 and 10, stay unchanged through an expiry, which only sets bit 5.
- R9: A keyed count write while armed reloads the count. It takes priority over a tick in the same cycle and prevents expiry in that cycle.
- R10: After synchronous reset all three registers read 0 and `reset_req` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle countdown strobe at the tick rate |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data; bits 31:24 carry the key |
| bus_rdata | output | 32 | Registered read data |
| reset_req | output | 1 | One-cycle reset request on watchdog expiry |

## Verification
The assertions check several rules on every cycle:
- an unkeyed write never disturbs a register;
- the count steps down by exactly one per armed tick and holds when disarmed;
- `reset_req` never lasts two cycles, and it always coincides with a cleared configuration field and a set expiry flag;
- status bits change only under a keyed status write.

The bench scenarios cover what the properties cannot show:
- the exact tick on which expiry lands for counts of 0 and 3;
- the value read back at each offset;
- a ping arriving in the same cycle as a tick;
- the stop value 0x102 freezing a partly spent count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] WR_KEY = 8'h5A;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CNT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wdog_bus_dec.sv
module wdog_bus_dec
  import wdog_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  CTRL_OFS = 8'h1C,
  parameter logic [7:0]  STAT_OFS = 8'h20,
  parameter logic [7:0]  CNT_OFS  = 8'h24
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [7:0]        key_byte,
  output logic              wr_ctrl,
  output logic              wr_stat,
  output logic              wr_cnt,
  output reg_sel_e          rd_sel
);
  logic key_ok;

  always_comb begin
    key_ok = (key_byte == WR_KEY);
    rd_sel = SEL_NONE;
    if (addr == ADDR_W'(CTRL_OFS))      rd_sel = SEL_CTRL;
    else if (addr == ADDR_W'(STAT_OFS)) rd_sel = SEL_STAT;
    else if (addr == ADDR_W'(CNT_OFS))  rd_sel = SEL_CNT;
    wr_ctrl = we && key_ok && (rd_sel == SEL_CTRL);
    wr_stat = we && key_ok && (rd_sel == SEL_STAT);
    wr_cnt  = we && key_ok && (rd_sel == SEL_CNT);
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs #(
  parameter int CTRL_W   = 12,
  parameter int STAT_W   = 12,
  parameter int CFG_LO   = 4,
  parameter int FLAG_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_stat,
  input  logic [31:0]       wdata,
  input  logic              expire,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [STAT_W-1:0] stat_q,
  output logic              armed
);
  localparam logic [STAT_W-1:0] FLAG_MASK = STAT_W'(1) << FLAG_BIT;

  logic [STAT_W-1:0] stat_d;

  always_comb begin
    stat_d = wr_stat ? wdata[STAT_W-1:0] : stat_q;
    if (expire) stat_d = stat_d | FLAG_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (expire)       ctrl_q[CFG_LO +: 2] <= 2'b00;
      else if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
    end
  end

  assign armed = ctrl_q[CFG_LO+1];

  AST_STAT_KEEP: assert property (@(posedge clk) disable iff (rst)
    !wr_stat |=> ((stat_q | FLAG_MASK) == ($past(stat_q) | FLAG_MASK))); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!wr_stat && stat_q[FLAG_BIT]) |=> stat_q[FLAG_BIT]); // R8
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             armed,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count_q,
  output logic             expire_now,
  output logic             reset_req
);
  always_comb
    expire_now = tick_en && armed && !load && (count_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '0;
      reset_req <= 1'b0;
    end else begin
      reset_req <= expire_now;
      if (load)                  count_q <= load_val;
      else if (tick_en && armed) count_q <= expire_now ? '0 : count_q - CNT_W'(1);
    end
  end

  AST_HOLD_DISARMED: assert property (@(posedge clk) disable iff (rst)
    (!armed && !load) |=> $stable(count_q)); // R4
  AST_DEC_ONE: assert property (@(posedge clk) disable iff (rst)
    (armed && tick_en && !load && count_q > CNT_W'(1)) |=> (count_q == $past(count_q) - CNT_W'(1))); // R4
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load |=> (!reset_req && count_q == $past(load_val))); // R9
endmodule

// File: rtl/wdog_reset_ctrl.sv
module wdog_reset_ctrl
  import wdog_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         CNT_W    = 20,
  parameter int         CTRL_W   = 12,
  parameter int         STAT_W   = 12,
  parameter logic [7:0] CTRL_OFS = 8'h1C,
  parameter logic [7:0] STAT_OFS = 8'h20,
  parameter logic [7:0] CNT_OFS  = 8'h24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              reset_req
);
  localparam int CFG_LO   = 4;
  localparam int FLAG_BIT = 5;

  logic              wr_ctrl, wr_stat, wr_cnt;
  reg_sel_e          rd_sel;
  logic [CTRL_W-1:0] ctrl_q;
  logic [STAT_W-1:0] stat_q;
  logic [CNT_W-1:0]  count_q;
  logic              armed, expire_now;

  wdog_bus_dec #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS), .CNT_OFS(CNT_OFS)
  ) u_dec (
    .addr(bus_addr), .we(bus_we), .key_byte(bus_wdata[31:24]),
    .wr_ctrl(wr_ctrl), .wr_stat(wr_stat), .wr_cnt(wr_cnt), .rd_sel(rd_sel)
  );

  wdog_regs #(
    .CTRL_W(CTRL_W), .STAT_W(STAT_W), .CFG_LO(CFG_LO), .FLAG_BIT(FLAG_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
    .wdata(bus_wdata), .expire(expire_now),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .armed(armed)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .armed(armed),
    .load(wr_cnt), .load_val(bus_wdata[CNT_W-1:0]),
    .count_q(count_q), .expire_now(expire_now), .reset_req(reset_req)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      unique case (rd_sel)
        SEL_CTRL: bus_rdata <= 32'(ctrl_q);
        SEL_STAT: bus_rdata <= 32'(stat_q);
        SEL_CNT:  bus_rdata <= 32'(count_q);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  AST_NO_KEY_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_wdata[31:24] != WR_KEY && !tick_en)
      |=> ($stable(ctrl_q) && $stable(stat_q) && $stable(count_q))); // R1
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req); // R6
  AST_EXPIRE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (ctrl_q[CFG_LO +: 2] == 2'b00 && stat_q[FLAG_BIT] && count_q == '0)); // R7
endmodule

// File: tb/tb_wdog_reset_ctrl.sv
module tb_wdog_reset_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        reset_req;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [7:0] A_CTRL = 8'h1C, A_STAT = 8'h20, A_CNT = 8'h24;

  always #2 clk = ~clk;

  wdog_reset_ctrl dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .reset_req(reset_req)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R10 reset_req", {31'b0, reset_req}, 32'd0);
    rd(A_CTRL, d); chk("R10 ctrl", d, 32'h0);
    rd(A_STAT, d); chk("R10 status", d, 32'h0);
    rd(A_CNT, d);  chk("R10 count", d, 32'h0);
  endtask

  task automatic t_key;
    logic [31:0] d;
    wr(A_CTRL, 32'h0000_0020);
    wr(A_CNT,  32'h5B00_0123);
    wr(A_STAT, 32'hA500_0555);
    rd(A_CTRL, d); chk("R1 ctrl unkeyed", d, 32'h0);
    rd(A_CNT, d);  chk("R1 count wrong key", d, 32'h0);
    rd(A_STAT, d); chk("R1 status unkeyed", d, 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    wr(A_CNT, 32'h5AFF_FFFF);
    rd(A_CNT, d); chk("R3 count width", d, 32'h000F_FFFF);
    wr(A_CNT, 32'h5A0A_BCDE);
    rd(A_CNT, d); chk("R3 count value", d, 32'h000A_BCDE);
    rd(8'h28, d); chk("R2 unmapped", d, 32'h0);
    rd(8'h18, d); chk("R2 unmapped low", d, 32'h0);
  endtask

  task automatic t_count_stop;
    logic [31:0] d;
    wr(A_CNT, 32'h5A00_0005);
    ticks(3);
    rd(A_CNT, d); chk("R4 hold disarmed", d, 32'd5);
    wr(A_CTRL, 32'h5A00_0020);
    rd(A_CTRL, d); chk("R2 ctrl readback", d, 32'h20);
    ticks(3);
    rd(A_CNT, d); chk("R4 countdown", d, 32'd2);
    wr(A_CTRL, 32'h5A00_0102);
    rd(A_CTRL, d); chk("R5 stop value", d, 32'h102);
    ticks(2);
    rd(A_CNT, d); chk("R5 frozen count", d, 32'd2);
    chk("R5 no reset", {31'b0, reset_req}, 32'd0);
  endtask

  task automatic t_expire;
    logic [31:0] d;
    wr(A_CNT, 32'h5A00_0003);
    wr(A_CTRL, 32'h5A00_0120);
    ticks(2);
    chk("R6 not early", {31'b0, reset_req}, 32'd0);
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    chk("R6 pulse high", {31'b0, reset_req}, 32'd1);
    @(negedge clk);
    chk("R6 pulse one cycle", {31'b0, reset_req}, 32'd0);
    rd(A_CTRL, d); chk("R7 cfg cleared", d, 32'h100);
    rd(A_STAT, d); chk("R7 flag set", d, 32'h20);
    rd(A_CNT, d);  chk("R7 count zero", d, 32'h0);
  endtask

  task automatic t_zero;
    wr(A_CNT, 32'h5A00_0000);
    wr(A_CTRL, 32'h5A00_0020);
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    chk("R6 zero count next tick", {31'b0, reset_req}, 32'd1);
  endtask

  task automatic t_status;
    logic [31:0] d;
    wr(A_STAT, 32'h5A00_0000);
    wr(A_STAT, 32'h5A00_F555);
    rd(A_STAT, d); chk("R8 keyed status", d, 32'h555);
    wr(A_CNT, 32'h5A00_0001);
    wr(A_CTRL, 32'h5A00_0020);
    ticks(1);
    rd(A_STAT, d); chk("R8 preserved on expiry", d, 32'h575);
    wr(A_STAT, 32'h0000_0000);
    rd(A_STAT, d); chk("R1 status kept", d, 32'h575);
  endtask

  task automatic t_ping;
    logic [31:0] d;
    logic        seen;
    seen = 1'b0;
    wr(A_CNT, 32'h5A00_0004);
    wr(A_CTRL, 32'h5A00_0020);
    ticks(3);
    rd(A_CNT, d); chk("R9 before ping", d, 32'd1);
    @(negedge clk);
    bus_addr = A_CNT; bus_we = 1'b1; bus_wdata = 32'h5A00_0004; tick_en = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick_en = 1'b0;
    seen = reset_req;
    chk("R9 ping beats tick", {31'b0, seen}, 32'd0);
    rd(A_CNT, d); chk("R9 reloaded", d, 32'd4);
    ticks(3);
    chk("R9 no reset after ping", {31'b0, reset_req}, 32'd0);
    rd(A_CNT, d); chk("R9 count after ping", d, 32'd1);
    wr(A_CTRL, 32'h5A00_0102);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_key();
    t_map();
    t_count_stop();
    t_expire();
    t_zero();
    t_status();
    t_ping();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule